// File: doc/BRIEF.md
# Flash Program and Erase Timing Sequencer

This block sequences nonvolatile-memory write and erase operations. It counts fixed numbers of timing-generator ticks for each phase. A host raises a one-cycle command strobe that carries an operation code, a byte address and the first data word. The sequencer then stays busy while the operation runs. When a timed phase finishes, it emits a commit strobe, and the storage array and its high-voltage control act on that strobe. The block handles four kinds of operation: a single word program, a block program of consecutive words, a single segment erase, and a bulk erase. A bulk erase covers either the main area alone or the main area together with the information area.

In a block program, the host streams the later words through a valid/ready handshake. A one-entry holding register sits between the host and the sequencer. When no word is ready at the end of an entry, the sequencer pauses and keeps its phase count frozen until the next word arrives. The topmost information segment holds calibration data and is write-protected from reset. An operation aimed at that segment while it is protected is refused, and the block raises an access-violation flag in its place.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `acc_viol`, `blk_ready` and both commit strobes are low, and `seg_a_locked` is high.
- R2: Operation code 1 (word program) keeps `busy` high for exactly 30 ticks. It ends with one `prog_pulse` carrying the command's address and data, together with one `done` pulse. Codes 0, 6 and 7 start nothing.
- R3: Operation code 2 (block program) spends 25 ticks on the first entry, 18 ticks on each later entry and 6 ticks on a closing phase. Each entry gives one `prog_pulse`, and the address advances by DW/8 bytes per entry. An entry flagged last (`cmd_last` or `blk_last`) ends the block.
- R4: A block never exceeds 64 bytes. Once 32 words (at DW=16) have been taken, `blk_ready` stays low and the block closes after the 32nd entry.
- R5: When an entry finishes and no next word is held, `waiting` goes high and no tick is counted. Total busy time equals 49 ticks plus the waiting cycles for a two-entry block.
- R6: Code 3 (segment erase) takes 4819 ticks. Codes 4 (main-only bulk erase) and 5 (main plus information bulk erase) take 10593 ticks. Each ends with one `erase_pulse` whose `erase_mass`/`erase_info` flags are 0/0, 1/0 and 1/1 respectively.
- R7: The protected segment spans addresses 0x10C0 to 0x10FF (page 0x10, segment index 3 of four 64-byte information segments). While it is locked, codes 1, 2 and 3 aimed into it, and code 5, are refused. A refused command does not raise `busy` and sets `acc_viol` one cycle later. `acc_viol` is cleared by the next accepted command.
- R8: `unlock_a` clears the protection and `lock_a` sets it again; when both are high, `lock_a` wins. Operations on other segments, and code 4, are never refused.
- R9: A command strobe while `busy` is high is ignored.
- R10: Phase counts advance only on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing-generator tick (count enable) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | AW | Target byte address |
| cmd_data | input | DW | First data word |
| cmd_last | input | 1 | First block word is also the last |
| blk_valid | input | 1 | Next block word offered |
| blk_data | input | DW | Next block word |
| blk_last | input | 1 | Offered word is the last |
| blk_ready | output | 1 | Block word accepted when valid |
| unlock_a | input | 1 | Remove protection of the calibration segment |
| lock_a | input | 1 | Restore protection |
| busy | output | 1 | Operation in progress |
| waiting | output | 1 | Block paused for data |
| prog_pulse | output | 1 | Program commit strobe |
| prog_addr | output | AW | Committed address |
| prog_data | output | DW | Committed data |
| erase_pulse | output | 1 | Erase commit strobe |
| erase_addr | output | AW | Erase target address |
| erase_mass | output | 1 | Erase covers all main segments |
| erase_info | output | 1 | Erase also covers information segments |
| done | output | 1 | Operation finished |
| acc_viol | output | 1 | Last command was refused |
| seg_a_locked | output | 1 | Protection state |

## Verification
The checker watches several properties on every cycle. `done` and a freshly raised `acc_viol` never coincide with `busy`. The two commit strobes never fire together, and a commit strobe only follows a busy cycle. `blk_ready` is only high during an operation. Without a tick, no phase completes. The protection state changes only on a control pulse. The exact tick counts per phase, the address stepping, the 64-byte cap, the frozen count during a data pause and the refusal of protected targets depend on sequences of commands. Those are shown by the bench's directed scenarios.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WORD  = 3'd1,
    OP_BLOCK = 3'd2,
    OP_SEG   = 3'd3,
    OP_MAIN  = 3'd4,
    OP_ALL   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WORD,
    S_BFIRST,
    S_BNEXT,
    S_BWAIT,
    S_BEND,
    S_ERASE
  } st_e;
endpackage

// File: rtl/flseq_timer.sv
// Down-counter for one timed phase; expires on the tick that finds it at zero.
module flseq_timer #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_n;

  assign expire = run && tick && (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (load)                             cnt_n = load_val;
    else if (run && tick && cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/flseq_region.sv
// Classifies an address against the protected calibration segment.
module flseq_region #(
  parameter int AW        = 16,
  parameter int INFO_PAGE = 16'h0010,
  parameter int INFO_SEGS = 4,
  parameter int INFO_SEG_BYTES = 64,
  parameter int PROT_IDX  = 3
) (
  input  logic [AW-1:0] addr,
  output logic          in_prot
);
  localparam int OFS_W = $clog2(INFO_SEG_BYTES);
  localparam int IDX_W = $clog2(INFO_SEGS);
  localparam int PG_LO = OFS_W + IDX_W;

  logic [AW-PG_LO-1:0] page;
  logic [IDX_W-1:0]    idx;

  assign page    = addr[AW-1:PG_LO];
  assign idx     = addr[PG_LO-1:OFS_W];
  assign in_prot = (page == (AW-PG_LO)'(INFO_PAGE)) && (idx == IDX_W'(PROT_IDX));
endmodule

// File: rtl/flseq_lock.sv
// Protection register for the calibration segment; locked out of reset.
module flseq_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic unlock,
  input  logic lock,
  output logic locked
);
  logic locked_n;

  always_comb begin
    locked_n = locked;
    if (lock)        locked_n = 1'b1;
    else if (unlock) locked_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b1;
    else        locked <= locked_n;
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flseq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int T_WORD    = 30,
  parameter int T_FIRST   = 25,
  parameter int T_NEXT    = 18,
  parameter int T_END     = 6,
  parameter int T_SEG     = 4819,
  parameter int T_MASS    = 10593,
  parameter int BLK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_last,
  input  logic          blk_valid,
  input  logic [DW-1:0] blk_data,
  input  logic          blk_last,
  output logic          blk_ready,
  input  logic          unlock_a,
  input  logic          lock_a,
  output logic          busy,
  output logic          waiting,
  output logic          prog_pulse,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          erase_pulse,
  output logic [AW-1:0] erase_addr,
  output logic          erase_mass,
  output logic          erase_info,
  output logic          done,
  output logic          acc_viol,
  output logic          seg_a_locked
);
  localparam int STEP    = DW / 8;
  localparam int BLK_MAX = BLK_BYTES / STEP;
  localparam int T_BIG   = (T_MASS > T_SEG) ? T_MASS : T_SEG;
  localparam int CW      = $clog2(T_BIG + 1);
  localparam int TW      = $clog2(BLK_MAX + 1);
  localparam logic [TW-1:0] BLK_MAX_T = TW'(BLK_MAX);

  st_e           st_q, st_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic          last_q, last_n;
  logic [TW-1:0] taken_q, taken_n;
  logic          hold_v_q, hold_v_n;
  logic [DW-1:0] hold_d_q, hold_d_n;
  logic          hold_l_q, hold_l_n;
  logic          viol_q, viol_n;
  logic          mass_q, mass_n, info_q, info_n;
  logic          prog_q, prog_n, erase_q, erase_n, done_q, done_n;
  logic [AW-1:0] paddr_q;
  logic [DW-1:0] pdata_q;

  logic          ld, expire, run, next_go, in_prot, locked, blocked, op_ok, accept;
  logic [CW-1:0] ld_val;
  op_e           op;

  flseq_lock u_lock (
    .clk(clk), .rst_n(rst_n), .unlock(unlock_a), .lock(lock_a), .locked(locked)
  );

  flseq_region #(.AW(AW)) u_region (
    .addr(cmd_addr), .in_prot(in_prot)
  );

  flseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .load(ld), .load_val(ld_val), .expire(expire)
  );

  assign op    = op_e'(cmd_op);
  assign op_ok = (op == OP_WORD) || (op == OP_BLOCK) || (op == OP_SEG) ||
                 (op == OP_MAIN) || (op == OP_ALL);
  assign blocked = locked && ((op == OP_ALL) ||
                   (in_prot && (op == OP_WORD || op == OP_BLOCK || op == OP_SEG)));

  assign run = (st_q == S_WORD) || (st_q == S_BFIRST) || (st_q == S_BNEXT) ||
               (st_q == S_BEND) || (st_q == S_ERASE);
  assign blk_ready = ((st_q == S_BFIRST) || (st_q == S_BNEXT) || (st_q == S_BWAIT)) &&
                     !hold_v_q && !last_q && (taken_q != BLK_MAX_T);
  assign accept = blk_valid && blk_ready;

  always_comb begin
    st_n = st_q;  addr_n = addr_q;  data_n = data_q;  last_n = last_q;
    taken_n = taken_q;  hold_v_n = hold_v_q;  hold_d_n = hold_d_q;  hold_l_n = hold_l_q;
    viol_n = viol_q;  mass_n = mass_q;  info_n = info_q;
    ld = 1'b0;  ld_val = '0;  next_go = 1'b0;
    prog_n = 1'b0;  erase_n = 1'b0;  done_n = 1'b0;

    if (accept) begin
      hold_v_n = 1'b1;
      hold_d_n = blk_data;
      hold_l_n = blk_last;
      taken_n  = taken_q + 1'b1;
    end

    case (st_q)
      S_IDLE: begin
        if (cmd_valid && op_ok) begin
          if (blocked) begin
            viol_n = 1'b1;
          end else begin
            viol_n   = 1'b0;
            addr_n   = cmd_addr;
            data_n   = cmd_data;
            last_n   = cmd_last;
            taken_n  = TW'(1);
            hold_v_n = 1'b0;
            mass_n   = (op == OP_MAIN) || (op == OP_ALL);
            info_n   = (op == OP_ALL);
            ld       = 1'b1;
            case (op)
              OP_WORD:  begin st_n = S_WORD;   ld_val = CW'(T_WORD - 1);  end
              OP_BLOCK: begin st_n = S_BFIRST; ld_val = CW'(T_FIRST - 1); end
              OP_SEG:   begin st_n = S_ERASE;  ld_val = CW'(T_SEG - 1);   end
              default:  begin st_n = S_ERASE;  ld_val = CW'(T_MASS - 1);  end
            endcase
          end
        end
      end
      S_WORD: begin
        if (expire) begin
          prog_n = 1'b1;  done_n = 1'b1;  st_n = S_IDLE;
        end
      end
      S_BFIRST, S_BNEXT: begin
        if (expire) begin
          prog_n = 1'b1;
          if (last_q || (!hold_v_q && taken_q == BLK_MAX_T)) begin
            st_n = S_BEND;  ld = 1'b1;  ld_val = CW'(T_END - 1);
          end else if (hold_v_q) begin
            next_go = 1'b1;
          end else begin
            st_n = S_BWAIT;
          end
        end
      end
      S_BWAIT: begin
        if (hold_v_q) next_go = 1'b1;
      end
      S_BEND: begin
        if (expire) begin
          done_n = 1'b1;  st_n = S_IDLE;
        end
      end
      S_ERASE: begin
        if (expire) begin
          erase_n = 1'b1;  done_n = 1'b1;  st_n = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase

    if (next_go) begin
      st_n     = S_BNEXT;
      ld       = 1'b1;
      ld_val   = CW'(T_NEXT - 1);
      addr_n   = addr_q + AW'(STEP);
      data_n   = hold_d_q;
      last_n   = hold_l_q;
      hold_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  addr_q <= '0;  data_q <= '0;  last_q <= 1'b0;
      taken_q <= '0;  hold_v_q <= 1'b0;  hold_d_q <= '0;  hold_l_q <= 1'b0;
      viol_q <= 1'b0;  mass_q <= 1'b0;  info_q <= 1'b0;
      prog_q <= 1'b0;  erase_q <= 1'b0;  done_q <= 1'b0;
    end else begin
      st_q <= st_n;  addr_q <= addr_n;  data_q <= data_n;  last_q <= last_n;
      taken_q <= taken_n;  hold_v_q <= hold_v_n;  hold_d_q <= hold_d_n;  hold_l_q <= hold_l_n;
      viol_q <= viol_n;  mass_q <= mass_n;  info_q <= info_n;
      prog_q <= prog_n;  erase_q <= erase_n;  done_q <= done_n;
    end
  end

  // Commit address and data are captured only when a program phase completes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      pdata_q <= '0;
    end else if (prog_n) begin
      paddr_q <= addr_q;
      pdata_q <= data_q;
    end
  end

  assign busy         = (st_q != S_IDLE);
  assign waiting      = (st_q == S_BWAIT);
  assign prog_pulse   = prog_q;
  assign prog_addr    = paddr_q;
  assign prog_data    = pdata_q;
  assign erase_pulse  = erase_q;
  assign erase_addr   = addr_q;
  assign erase_mass   = mass_q;
  assign erase_info   = info_q;
  assign done         = done_q;
  assign acc_viol     = viol_q;
  assign seg_a_locked = locked;
endmodule

// File: rtl/flseq_chk.sv
module flseq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic busy,
  input logic done,
  input logic acc_viol,
  input logic blk_ready,
  input logic prog_pulse,
  input logic erase_pulse,
  input logic seg_a_locked,
  input logic unlock_a,
  input logic lock_a
);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_prog_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> $past(busy));

  p_ready_in_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> busy);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_pulse && erase_pulse));

  p_refuse_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_viol) |-> !busy);

  p_lock_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlock_a && !lock_a) |=> $stable(seg_a_locked));

  p_no_tick_no_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> !done);
endmodule

bind flash_seq_ctrl flseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .done(done),
  .acc_viol(acc_viol), .blk_ready(blk_ready), .prog_pulse(prog_pulse),
  .erase_pulse(erase_pulse), .seg_a_locked(seg_a_locked),
  .unlock_a(unlock_a), .lock_a(lock_a)
);

// File: tb/flash_seq_ctrl_tb.sv
module flash_seq_ctrl_tb;
  logic        clk, rst_n, tick, cmd_valid, cmd_last, blk_valid, blk_last;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_addr, cmd_data, blk_data;
  logic        unlock_a, lock_a;
  logic        blk_ready, busy, waiting, prog_pulse, erase_pulse;
  logic        erase_mass, erase_info, done, acc_viol, seg_a_locked;
  logic [15:0] prog_addr, prog_data, erase_addr;

  int n_chk, n_fail, cyc;
  int busy_n, prog_n, erase_n, done_n, wait_n;
  logic [15:0] first_paddr, last_paddr, last_pdata;
  logic        e_mass, e_info, tick_alt;

  flash_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_last(blk_last),
    .blk_ready(blk_ready), .unlock_a(unlock_a), .lock_a(lock_a), .busy(busy),
    .waiting(waiting), .prog_pulse(prog_pulse), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_pulse(erase_pulse), .erase_addr(erase_addr),
    .erase_mass(erase_mass), .erase_info(erase_info), .done(done),
    .acc_viol(acc_viol), .seg_a_locked(seg_a_locked)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d expected below 190000 cycles", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (busy) busy_n++;
    if (waiting) wait_n++;
    if (done) done_n++;
    if (prog_pulse) begin
      if (prog_n == 0) first_paddr = prog_addr;
      prog_n++;
      last_paddr = prog_addr;
      last_pdata = prog_data;
    end
    if (erase_pulse) begin
      erase_n++;
      e_mass = erase_mass;
      e_info = erase_info;
    end
    if (tick_alt) tick = ~tick;
    else          tick = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    busy_n = 0; prog_n = 0; erase_n = 0; done_n = 0; wait_n = 0;
    e_mass = 1'b0; e_info = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] a,
                       input logic [15:0] d, input logic lst);
    @(negedge clk);
    clear_mon();
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_last = lst;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 12000 && done_n == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Streams block words; word i carries data base+i. gap: waiting cycles before word 1.
  task automatic run_block(input logic [15:0] a, input logic [15:0] base,
                           input int n_send, input bit use_last, input int gap);
    int idx = 1;
    int wl = 0;
    bit acc = 1'b0;
    issue(3'd2, a, base, use_last && n_send == 1);
    for (int k = 0; k < 5000 && done_n == 0; k++) begin
      if (acc) idx++;
      if (waiting) wl++;
      if (idx < n_send && (idx != 1 || wl >= gap)) begin
        blk_valid = 1'b1;
        blk_data  = base + 16'(idx);
        blk_last  = use_last && (idx == n_send - 1);
      end else begin
        blk_valid = 1'b0;
      end
      acc = blk_valid && blk_ready;
      @(negedge clk);
    end
    blk_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 acc_viol", acc_viol, 0);
    chk("R1 blk_ready", blk_ready, 0);
    chk("R1 strobes", prog_pulse | erase_pulse, 0);
    chk("R1 seg_a_locked", seg_a_locked, 1);
  endtask

  task automatic t_word();
    issue(3'd1, 16'hF000, 16'h1234, 1'b0);
    wait_end();
    chk("R2 busy ticks", busy_n, 30);
    chk("R2 commits", prog_n, 1);
    chk("R2 addr", last_paddr, 16'hF000);
    chk("R2 data", last_pdata, 16'h1234);
    chk("R2 done", done_n, 1);
    issue(3'd6, 16'hF000, 16'h1, 1'b0);
    repeat (5) @(negedge clk);
    chk("R2 unused code busy", busy_n, 0);
  endtask

  task automatic t_block3();
    run_block(16'hE000, 16'h0A00, 3, 1'b1, 0);
    chk("R3 busy 25+18+18+6", busy_n, 67);
    chk("R3 commits", prog_n, 3);
    chk("R3 first addr", first_paddr, 16'hE000);
    chk("R3 last addr", last_paddr, 16'hE004);
    chk("R3 last data", last_pdata, 16'h0A02);
    run_block(16'hE100, 16'h0B00, 1, 1'b1, 0);
    chk("R3 single entry busy", busy_n, 31);
  endtask

  task automatic t_cap();
    run_block(16'hE200, 16'h0C00, 40, 1'b0, 0);
    chk("R4 commits capped", prog_n, 32);
    chk("R4 busy", busy_n, 25 + 31 * 18 + 6);
    chk("R4 last addr", last_paddr, 16'hE23E);
    chk("R4 ready low after", blk_ready, 0);
  endtask

  task automatic t_wait();
    run_block(16'hE300, 16'h0D00, 2, 1'b1, 10);
    chk("R5 waited", (wait_n >= 10) ? 1 : 0, 1);
    chk("R5 busy frozen count", busy_n, 49 + wait_n);
    chk("R5 commits", prog_n, 2);
    chk("R5 data", last_pdata, 16'h0D01);
  endtask

  task automatic t_erase();
    issue(3'd3, 16'hE400, 16'h0, 1'b0);
    wait_end();
    chk("R6 seg busy", busy_n, 4819);
    chk("R6 seg strobe", erase_n, 1);
    chk("R6 seg flags", {e_mass, e_info}, 0);
    issue(3'd4, 16'h0000, 16'h0, 1'b0);
    wait_end();
    chk("R6 main busy", busy_n, 10593);
    chk("R6 main flags", {e_mass, e_info}, 2);
  endtask

  task automatic t_violate();
    issue(3'd1, 16'h10C4, 16'h5555, 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 word refused busy", busy_n, 0);
    chk("R7 acc_viol", acc_viol, 1);
    issue(3'd3, 16'h10FE, 16'h0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 seg erase refused", busy_n + erase_n, 0);
    issue(3'd5, 16'h0000, 16'h0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 all erase refused", busy_n, 0);
    issue(3'd1, 16'h1000, 16'h7777, 1'b0);
    wait_end();
    chk("R8 unprotected info seg ok", prog_n, 1);
    chk("R7 viol cleared", acc_viol, 0);
  endtask

  task automatic t_unlock();
    @(negedge clk); unlock_a = 1'b1;
    @(negedge clk); unlock_a = 1'b0;
    chk("R8 unlocked", seg_a_locked, 0);
    issue(3'd1, 16'h10C0, 16'h4242, 1'b0);
    wait_end();
    chk("R8 prog seg A", prog_n, 1);
    issue(3'd5, 16'h0000, 16'h0, 1'b0);
    wait_end();
    chk("R6 all busy", busy_n, 10593);
    chk("R6 all flags", {e_mass, e_info}, 3);
    @(negedge clk); lock_a = 1'b1; unlock_a = 1'b1;
    @(negedge clk); lock_a = 1'b0; unlock_a = 1'b0;
    chk("R8 lock wins", seg_a_locked, 1);
    issue(3'd2, 16'h10D0, 16'h1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R8 relocked refuses", acc_viol, 1);
  endtask

  task automatic t_ignore();
    issue(3'd1, 16'hF100, 16'h1111, 1'b0);
    repeat (5) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 16'hF200; cmd_data = 16'h2222;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_end();
    chk("R9 one commit", prog_n, 1);
    chk("R9 first data kept", last_pdata, 16'h1111);
    chk("R9 busy unchanged", busy_n, 30);
  endtask

  task automatic t_tick();
    tick_alt = 1'b1;
    issue(3'd1, 16'hF300, 16'h3333, 1'b0);
    wait_end();
    tick_alt = 1'b0;
    chk("R10 busy spans half-rate ticks", (busy_n >= 59 && busy_n <= 60) ? 1 : 0, 1);
    chk("R10 commit", prog_n, 1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; tick_alt = 1'b0; tick = 1'b1;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_addr = '0; cmd_data = '0;
    cmd_last = 1'b0; blk_valid = 1'b0; blk_data = '0; blk_last = 1'b0;
    unlock_a = 1'b0; lock_a = 1'b0;
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_block3();
    t_cap();
    t_wait();
    t_erase();
    t_violate();
    t_unlock();
    t_ignore();
    t_tick();
    summary();
  end
endmodule